// File: doc/BRIEF.md
# Variable-Timeout Watchdog Timer

This block supervises a processor by counting down from a value that firmware supplies. Each service write to the reload register stores a new timeout and restarts the countdown from it in the same clock edge, so firmware can lengthen or shorten the allowed interval from one service to the next. If the count drops below zero before the next service write, the watchdog acts. Depending on a control bit, it either sends a one-cycle reset request to the local processor or raises a sticky alarm line for a system controller outside the core. It never produces an interrupt. The only way to service it is an explicit write.

Expiry is taken from an extra sign bit above the count magnitude, which amounts to a "less than zero" test rather than a match against a fixed value. If a disturbance flips counter bits, the count cannot step over a single trip value and go on running. A lock bit, once set while the watchdog runs, freezes the control register but leaves the reload register writable. Three power and debug conditions can each be told to suspend the watchdog.

The controller is a five-state machine:
- ST_OFF: disabled, and the counter follows the reload value.
- ST_RUN: counting down.
- ST_HOLD: paused for debug or sleep, with the count frozen.
- ST_DEEP: deep-sleep shutdown, with the counter kept at the reload value.
- ST_FIRE: one cycle in which the timeout action happens and the counter is reloaded.

The transitions are:
- ST_OFF goes to ST_RUN when the enable bit is set.
- ST_RUN goes to ST_FIRE when the sign bit is set, otherwise to ST_DEEP when deep sleep is requested, otherwise to ST_HOLD when a pause is requested.
- ST_HOLD goes to ST_DEEP when deep sleep is requested, and back to ST_RUN when the pause ends.
- ST_DEEP goes to ST_RUN on deep-sleep exit.
- ST_FIRE goes back to ST_RUN.
- Every state goes to ST_OFF when the enable bit is cleared.

Top module: `vt_watchdog`

## Requirements
- R1: A write to offset 0x4 (reload) stores its low CNT_W bits as the reload value and loads them into the counter at the same edge. This is accepted in every state and whether or not the lock bit is set.
- R2: While running, the counter falls by one per clock. After a reload write of value D, the timeout action happens in the cycle D+2 edges after the write edge. D=0 is a valid boundary.
- R3: Expiry is taken from the counter's sign bit (bit CNT_W, count below zero). After acting, the counter reloads and counting resumes, so an unserviced watchdog acts again every D+3 cycles.
- R4: While control bits lock (bit1) and enable (bit0) are both 1, writes to the control register at offset 0x0 are ignored. Reload writes still take effect.
- R5: The lock bit can be cleared only by reset. When the watchdog is not enabled, a control write may change the other bits but not clear lock.
- R6: If bit2 is 1, the count freezes while cpu_debug is high. If bit3 is 1, the count freezes while cpu_sleep is high. Without the matching bit, the input has no effect.
- R7: If bit4 is 1 and cpu_deep is high, the watchdog cannot expire and the counter is held at the reload value. On exit, counting resumes from the reload value.
- R8: With action bit5 = 0, expiry drives cpu_reset_req high for exactly one cycle and sys_alarm stays low.
- R9: With action bit5 = 1, sys_alarm rises one cycle after the expiry state (D+3 edges after the write) and stays high until reset. cpu_reset_req stays low.
- R10: After reset:
  - control reads 0;
  - reload reads all ones;
  - alarm is 0 and the count is all ones.
  A disabled watchdog never acts, and its count follows the reload value.
- R11: Status at offset 0x8 is read-only and laid out as follows:
  - bit0 is the alarm;
  - bits CNT_W:1 hold the count magnitude;
  - bit CNT_W+1 is the sign.
  Writes to 0x8 change nothing. Reads of an unmapped offset, or with no read request, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Read data, combinational from the address |
| cpu_debug | input | 1 | Processor is in debug mode |
| cpu_sleep | input | 1 | Processor is in sleep mode |
| cpu_deep | input | 1 | System is in deep-sleep power state |
| cpu_reset_req | output | 1 | One-cycle reset request to the local processor |
| sys_alarm | output | 1 | Sticky alarm to the external system controller |

## Verification
The assertions take the following for granted:
- the register request is sampled only at a clock edge;
- the request and the three power-state inputs are stable around that edge.

The bench therefore changes them only on the falling edge. The assertions also assume that reset, not software, is the only way the alarm or lock can clear. The pause and deep-sleep inputs are held for many cycles at a time, and each is released while the watchdog is still enabled, so every ST_HOLD and ST_DEEP exit runs through the transitions the checkers watch.

// File: rtl/vt_wdog_pkg.sv
package vt_wdog_pkg;

    typedef enum logic [2:0] {
        ST_OFF  = 3'd0,
        ST_RUN  = 3'd1,
        ST_HOLD = 3'd2,
        ST_DEEP = 3'd3,
        ST_FIRE = 3'd4
    } wd_state_e;

    // Control word, bit0 (en) at the bottom
    typedef struct packed {
        logic act_alarm;   // bit5
        logic deep_off;    // bit4
        logic sleep_hold;  // bit3
        logic dbg_hold;    // bit2
        logic lock;        // bit1
        logic en;          // bit0
    } wd_ctrl_t;

    localparam int CTRL_BITS = 6;

endpackage

// File: rtl/vt_wdog_regs.sv
module vt_wdog_regs
    import vt_wdog_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              alarm_i,
    input  logic [CNT_W:0]    cnt_i,
    output wd_ctrl_t          ctrl_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic              refresh_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [ADDR_W-1:0] OFS_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_RELOAD = ADDR_W'(4);
    localparam logic [ADDR_W-1:0] OFS_STATUS = ADDR_W'(8);

    wd_ctrl_t         ctrl_q, ctrl_d;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ctrl, ctrl_frozen;
    logic             unused_wbits;

    assign unused_wbits = ^req_wdata;
    assign wr_ctrl      = req_valid && req_write && (req_addr == OFS_CTRL);
    assign refresh_o    = req_valid && req_write && (req_addr == OFS_RELOAD);
    assign ctrl_frozen  = ctrl_q.lock && ctrl_q.en;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_ctrl && !ctrl_frozen) begin
            ctrl_d      = wd_ctrl_t'(req_wdata[CTRL_BITS-1:0]);
            ctrl_d.lock = req_wdata[1] | ctrl_q.lock;   // lock only sets
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            reload_q <= '1;
        end else begin
            ctrl_q <= ctrl_d;
            if (refresh_o) begin
                reload_q <= req_wdata[CNT_W-1:0];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        if (req_valid && !req_write) begin
            case (req_addr)
                OFS_CTRL:   rdata_o[CTRL_BITS-1:0] = ctrl_q;
                OFS_RELOAD: rdata_o[CNT_W-1:0]     = reload_q;
                OFS_STATUS: begin
                    rdata_o[0]         = alarm_i;
                    rdata_o[CNT_W+1:1] = cnt_i;
                end
                default:    rdata_o = '0;
            endcase
        end
    end

    assign ctrl_o   = ctrl_q;
    assign reload_o = reload_q;

    // R4
    lock_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctrl && ctrl_q.lock && ctrl_q.en) |=> $stable(ctrl_q));

    // R5
    lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q.lock |=> ctrl_q.lock);

endmodule

// File: rtl/vt_wdog_count.sv
module vt_wdog_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             reload_i,
    input  logic [CNT_W-1:0] reload_val_i,
    input  logic             dec_i,
    output logic [CNT_W:0]   cnt_o,
    output logic             neg_o
);

    localparam int CW = CNT_W + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= {1'b0, {CNT_W{1'b1}}};
        end else if (load_i) begin
            cnt_q <= {1'b0, load_val_i};
        end else if (reload_i) begin
            cnt_q <= {1'b0, reload_val_i};
        end else if (dec_i) begin
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // below-zero test on the extra top bit, never an equality match
    assign neg_o = $signed(cnt_q) < $signed(CW'(0));
    assign cnt_o = cnt_q;

    // R1
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == {1'b0, $past(load_val_i)});

    // R2
    step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_i && !load_i && !reload_i) |=> cnt_q == $past(cnt_q) - CW'(1));

endmodule

// File: rtl/vt_wdog_fsm.sv
module vt_wdog_fsm
    import vt_wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  wd_ctrl_t  ctrl_i,
    input  logic      cpu_debug_i,
    input  logic      cpu_sleep_i,
    input  logic      cpu_deep_i,
    input  logic      neg_i,
    output logic      dec_o,
    output logic      reload_o,
    output logic      reset_req_o,
    output logic      alarm_o,
    output wd_state_e state_o
);

    wd_state_e state_q, state_d;
    logic      hold_req, deep_req, alarm_q;

    assign hold_req = (ctrl_i.dbg_hold && cpu_debug_i) || (ctrl_i.sleep_hold && cpu_sleep_i);
    assign deep_req = ctrl_i.deep_off && cpu_deep_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (ctrl_i.en) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (!ctrl_i.en)    state_d = ST_OFF;
                else if (neg_i)    state_d = ST_FIRE;
                else if (deep_req) state_d = ST_DEEP;
                else if (hold_req) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!ctrl_i.en)    state_d = ST_OFF;
                else if (deep_req) state_d = ST_DEEP;
                else if (!hold_req) state_d = ST_RUN;
            end
            ST_DEEP: begin
                if (!ctrl_i.en)    state_d = ST_OFF;
                else if (!deep_req) state_d = ST_RUN;
            end
            ST_FIRE: begin
                if (!ctrl_i.en) state_d = ST_OFF;
                else            state_d = ST_RUN;
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        dec_o       = 1'b0;
        reload_o    = 1'b0;
        reset_req_o = 1'b0;
        unique case (state_q)
            ST_OFF:  reload_o = 1'b1;
            ST_RUN:  dec_o    = (state_d == ST_RUN);
            ST_HOLD: dec_o    = 1'b0;
            ST_DEEP: reload_o = 1'b1;
            ST_FIRE: begin
                reload_o    = 1'b1;
                reset_req_o = !ctrl_i.act_alarm;
            end
            default: reload_o = 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) alarm_q <= 1'b0;
        else if (state_q == ST_FIRE && ctrl_i.act_alarm) alarm_q <= 1'b1;
    end

    assign alarm_o = alarm_q;
    assign state_o = state_q;

    // R3
    expire_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && neg_i && ctrl_i.en) |=> state_q == ST_FIRE);

    // R7
    deep_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DEEP) |=> state_q != ST_FIRE);

    // R8
    reset_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req_o |=> !reset_req_o);

    // R9
    alarm_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_o |=> alarm_o);

endmodule

// File: rtl/vt_watchdog.sv
module vt_watchdog
    import vt_wdog_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              cpu_debug,
    input  logic              cpu_sleep,
    input  logic              cpu_deep,
    output logic              cpu_reset_req,
    output logic              sys_alarm
);

    wd_ctrl_t         ctrl;
    logic [CNT_W-1:0] reload_val;
    logic [CNT_W:0]   cnt;
    logic             refresh, neg, dec, reload, alarm;
    wd_state_e        state;

    vt_wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .alarm_i   (alarm),
        .cnt_i     (cnt),
        .ctrl_o    (ctrl),
        .reload_o  (reload_val),
        .refresh_o (refresh),
        .rdata_o   (rsp_rdata)
    );

    vt_wdog_count #(.CNT_W(CNT_W)) u_count (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (refresh),
        .load_val_i   (req_wdata[CNT_W-1:0]),
        .reload_i     (reload),
        .reload_val_i (reload_val),
        .dec_i        (dec),
        .cnt_o        (cnt),
        .neg_o        (neg)
    );

    vt_wdog_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_i      (ctrl),
        .cpu_debug_i (cpu_debug),
        .cpu_sleep_i (cpu_sleep),
        .cpu_deep_i  (cpu_deep),
        .neg_i       (neg),
        .dec_o       (dec),
        .reload_o    (reload),
        .reset_req_o (cpu_reset_req),
        .alarm_o     (alarm),
        .state_o     (state)
    );

    assign sys_alarm = alarm;

    // R6
    hold_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !refresh) |=> $stable(cnt));

endmodule

// File: tb/vt_watchdog_test.sv
`timescale 1ns/1ps
module vt_watchdog_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [3:0]  req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] rsp_rdata;
    logic        cpu_debug = 1'b0, cpu_sleep = 1'b0, cpu_deep = 1'b0;
    logic        cpu_reset_req, sys_alarm;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    vt_watchdog uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
        .cpu_debug(cpu_debug), .cpu_sleep(cpu_sleep), .cpu_deep(cpu_deep),
        .cpu_reset_req(cpu_reset_req), .sys_alarm(sys_alarm)
    );

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All tasks start and end just after a falling edge.
    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(logic [3:0] a, logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(logic [3:0] a, output logic [31:0] d);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        #0.5;
        d = rsp_rdata;
        req_valid = 1'b0;
    endtask

    task automatic get_count(output logic [31:0] c);
        logic [31:0] s;
        bus_rd(4'h8, s);
        c = (s >> 1) & 32'h1FFFF;
    endtask

    task automatic apply_reset();
        rst_n = 1'b0;
        cpu_debug = 1'b0; cpu_sleep = 1'b0; cpu_deep = 1'b0;
        req_valid = 1'b0; req_write = 1'b0;
        step(3);
        rst_n = 1'b1;
        step(1);
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        apply_reset();
        bus_rd(4'h0, v); check("R10", "ctrl after reset", v, 32'h0);
        bus_rd(4'h4, v); check("R10", "reload after reset", v, 32'hFFFF);
        bus_rd(4'h8, v); check("R10", "status after reset", v, 32'h1FFFE);
        check("R10", "reset_req after reset", 32'(cpu_reset_req), 0);
        check("R10", "alarm after reset", 32'(sys_alarm), 0);
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_rd(4'h8, v); check("R11", "status write ignored", v, 32'h1FFFE);
        bus_rd(4'hC, v); check("R11", "unmapped read", v, 32'h0);
        bus_wr(4'h4, 32'd3);
        step(40);
        get_count(v); check("R10", "disabled count follows reload", v, 32'd3);
        check("R10", "disabled never acts", 32'(cpu_reset_req), 0);
    endtask

    task automatic t_reset_action(int d);
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, 32'h01);
        bus_wr(4'h4, 32'(d));
        get_count(v); check("R1", "count after reload write", v, 32'(d));
        for (int i = 1; i <= 2*d + 6; i++) begin
            step(1);
            check(d == 0 ? "R2 D=0" : "R2", "reset_req timing", 32'(cpu_reset_req),
                  32'((i == d + 2) || (i == 2*d + 5)));
            if (i <= d) begin
                get_count(v); check("R2", "count falls", v, 32'(d - i));
            end
            if (i == d + 3) begin
                get_count(v); check("R3", "reload after action", v, 32'(d));
            end
        end
        check("R8", "alarm stays low", 32'(sys_alarm), 0);
    endtask

    task automatic t_restart();
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, 32'h01);
        bus_wr(4'h4, 32'd30);
        step(20);
        bus_wr(4'h4, 32'd12);
        bus_rd(4'h4, v); check("R1", "new reload stored", v, 32'd12);
        get_count(v); check("R1", "count restarted", v, 32'd12);
        for (int i = 1; i <= 15; i++) begin
            step(1);
            check("R1", "pulse after restart", 32'(cpu_reset_req), 32'(i == 14));
        end
        for (int k = 0; k < 25; k++) begin
            bus_wr(4'h4, 32'd10);
            for (int i = 0; i < 5; i++) begin
                step(1);
                if (cpu_reset_req) check("R1", "serviced watchdog acted", 1, 0);
            end
        end
        check("R1", "serviced watchdog quiet", 32'(cpu_reset_req), 0);
    endtask

    task automatic t_alarm();
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, 32'h21);
        bus_wr(4'h4, 32'd5);
        for (int i = 1; i <= 20; i++) begin
            step(1);
            check("R9", "no reset in alarm mode", 32'(cpu_reset_req), 0);
            check("R9", "alarm timing", 32'(sys_alarm), 32'(i >= 8));
        end
        bus_wr(4'h4, 32'd100);
        bus_wr(4'h0, 32'h20);
        step(3);
        check("R9", "alarm sticky", 32'(sys_alarm), 1);
        bus_rd(4'h8, v); check("R11", "status alarm bit", v & 32'h1, 1);
        apply_reset();
        check("R9", "alarm cleared by reset", 32'(sys_alarm), 0);
    endtask

    task automatic t_pause(logic [31:0] ctrl, bit use_sleep, bit holds);
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, ctrl);
        bus_wr(4'h4, 32'd40);
        step(5);
        if (use_sleep) cpu_sleep = 1'b1; else cpu_debug = 1'b1;
        step(10);
        get_count(v); check("R6", "count during pause input", v, holds ? 32'd35 : 32'd25);
        cpu_sleep = 1'b0; cpu_debug = 1'b0;
        step(5);
        get_count(v); check("R6", "count after pause input", v, holds ? 32'd31 : 32'd20);
        check("R6", "no action", 32'(cpu_reset_req), 0);
    endtask

    task automatic t_deep();
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, 32'h11);
        bus_wr(4'h4, 32'd50);
        step(10);
        cpu_deep = 1'b1;
        for (int i = 0; i < 100; i++) begin
            step(1);
            if (cpu_reset_req) check("R7", "acted in deep sleep", 1, 0);
        end
        get_count(v); check("R7", "count held at reload", v, 32'd50);
        cpu_deep = 1'b0;
        step(1);
        get_count(v); check("R7", "resume from reload", v, 32'd50);
        step(1);
        get_count(v); check("R7", "counting resumed", v, 32'd49);
        bus_wr(4'h0, 32'h01);
        bus_wr(4'h4, 32'd50);
        step(5);
        cpu_deep = 1'b1;
        step(10);
        get_count(v); check("R7", "deep ignored without bit4", v, 32'd35);
        cpu_deep = 1'b0;
    endtask

    task automatic t_lock();
        logic [31:0] v;
        apply_reset();
        bus_wr(4'h0, 32'h03);
        bus_rd(4'h0, v); check("R4", "lock set", v, 32'h03);
        bus_wr(4'h0, 32'h00);
        bus_rd(4'h0, v); check("R4", "clear ignored", v, 32'h03);
        bus_wr(4'h0, 32'h21);
        bus_rd(4'h0, v); check("R4", "change ignored", v, 32'h03);
        bus_wr(4'h4, 32'd7);
        bus_rd(4'h4, v); check("R4", "reload accepted when locked", v, 32'd7);
        for (int i = 1; i <= 10; i++) begin
            step(1);
            check("R4", "locked watchdog acts", 32'(cpu_reset_req), 32'(i == 9));
        end
        apply_reset();
        bus_wr(4'h0, 32'h02);
        bus_wr(4'h0, 32'h00);
        bus_rd(4'h0, v); check("R5", "lock kept while disabled", v, 32'h02);
        bus_wr(4'h0, 32'h0C);
        bus_rd(4'h0, v); check("R5", "other bits writable", v, 32'h0E);
        bus_wr(4'h0, 32'h01);
        bus_rd(4'h0, v); check("R5", "enable with lock kept", v, 32'h03);
        bus_wr(4'h0, 32'h00);
        bus_rd(4'h0, v); check("R4", "frozen after enable", v, 32'h03);
    endtask

    initial begin
        #(4.0 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        step(1);
        t_reset_state();
        t_reset_action(10);
        t_reset_action(0);
        t_restart();
        t_alarm();
        t_pause(32'h05, 1'b0, 1'b1);
        t_pause(32'h09, 1'b1, 1'b1);
        t_pause(32'h01, 1'b0, 1'b0);
        t_pause(32'h01, 1'b1, 1'b0);
        t_pause(32'h05, 1'b1, 1'b0);
        t_deep();
        t_lock();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule